// File: doc/BRIEF.md
# Delay-Slot Program Sequencer

This unit holds the fetch address of a small microcontroller and applies control-flow requests that the decoder hands it once per executed instruction. A taken transfer is not applied at once. Its destination goes into a pending-target register, the next instruction (the delay slot) still runs at the following address, and only after that slot does the fetch address move to the destination. A pending value of zero means that no transfer is pending. For this reason address zero can be reached only by reset.

The unit supports four conditional branches that add a signed offset to the current address. It also supports a call and a return through an 8-entry return-address stack, branch-and-link with return through a link register, and a jump to an address taken from a general register. Call and link both save the current address plus two, which is the first instruction after the delay slot. A repeat flag re-executes one plain instruction while a remaining-count register is nonzero, and decrements that register on every pass. A wait-for-input request issued while a transfer is pending is reported as an error. Illegal stack use is also reported.

Top module: `dslot_seq`

## Requirements
- R1: After reset the fetch address, stack pointer, link register, remaining count, pending flag and error output are all zero.
- R2: While `step_i` is low, the fetch address, stack pointer, link register and pending target keep their values whatever the request fields carry.
- R3: A step with no pending target and no repeat flag moves the fetch address to the current address plus one.
- R4: Op codes 1 to 4 are conditional branches. Code 1 is taken when the operand differs from the zero-extended immediate. Code 2 is taken when they are equal. Code 3 is taken when operand bit `bit_i` is 0. Code 4 is taken when that bit is 1. The target is the current address plus the sign-extended `ofs_i`.
- R5: After a taken transfer, the next step executes at the current address plus one, and the step after that lands on the target. A transfer taken in a delay slot takes effect one instruction after the first target.
- R6: Call (code 5) stores the current address plus two on the stack, increments the stack pointer and targets `lit_i`. Return (code 6) targets the newest entry and decrements the stack pointer.
- R7: The stack holds 8 entries. A call with 8 entries stored, or a return with none stored, pulses `err_o` in the cycle after the step, leaves the stack pointer unchanged and records no target.
- R8: Branch-and-link (code 7) sets the link register to the current address plus two and targets `lit_i`. Link return (code 9) targets the link register. Jump-register (code 8) targets the low bits of the operand.
- R9: With `rep_i` set, the op field is treated as code 0. If the count is above 1, the step decrements it and holds the address and any pending target. If the count is 1, the step decrements it to 0 and advances normally. If the count is 0, the step leaves the count at 0 and advances normally.
- R10: `rem_load_i` writes `rem_val_i` into the remaining count on that edge and takes priority over a decrement. Otherwise the count changes only through R9.
- R11: Wait-for-input (code 10) while a target is pending pulses `err_o` in the cycle after the step. Without a pending target it behaves as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One instruction executes this cycle |
| op_i | input | 4 | Control-flow request code |
| rep_i | input | 1 | Repeat flag of the executing instruction |
| opnd_i | input | 32 | General register operand |
| imm_i | input | 16 | Compare immediate |
| bit_i | input | 5 | Bit index for bit tests |
| ofs_i | input | 8 | Signed branch offset |
| lit_i | input | 12 | Literal destination for call and link |
| rem_load_i | input | 1 | Load the remaining count |
| rem_val_i | input | 16 | Value for the remaining count |
| pc_o | output | 12 | Fetch address |
| sp_o | output | 4 | Stack pointer, number of stored entries |
| lr_o | output | 12 | Link register |
| rem_o | output | 16 | Remaining count |
| pend_o | output | 1 | A transfer target is pending |
| err_o | output | 1 | Illegal stack use or wait with pending target |

## Verification
The assertions check the following on every cycle: that state holds when no step is issued, the plain one-step advance, the stack-pointer bound, that the stack pointer stays put under an error, the push on a legal call, the wait error, and the hold or skip of the repeat counter. The bench scenarios are needed for the delay-slot ordering, including a branch inside a delay slot. They are also needed for the exact branch targets of each condition, the return addresses coming back from the stack and the link register, the full and empty stack limits, and a repeat that holds a pending target across its passes.

// File: rtl/dslot_seq_pkg.sv
package dslot_seq_pkg;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_BNE_I = 4'd1,
        OP_BEQ_I = 4'd2,
        OP_BCLR  = 4'd3,
        OP_BSET  = 4'd4,
        OP_CALL  = 4'd5,
        OP_RET   = 4'd6,
        OP_BL    = 4'd7,
        OP_JR    = 4'd8,
        OP_SRET  = 4'd9,
        OP_WAIT  = 4'd10
    } seq_op_e;

endpackage

// File: rtl/dslot_cond.sv
module dslot_cond
    import dslot_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  seq_op_e           op_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [BIT_W-1:0]  bit_i,
    output logic              taken_o
);

    logic [DATA_W-1:0] imm_ext;
    logic              eq;
    logic              sel_bit;

    assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_i};
    assign eq      = (opnd_i == imm_ext);
    assign sel_bit = opnd_i[bit_i];

    always_comb begin
        case (op_i)
            OP_BNE_I: taken_o = !eq;
            OP_BEQ_I: taken_o = eq;
            OP_BCLR:  taken_o = !sel_bit;
            OP_BSET:  taken_o = sel_bit;
            default:  taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dslot_stack.sv
module dslot_stack #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 12,
    localparam int AW   = $clog2(DEPTH),
    localparam int SP_W = $clog2(DEPTH+1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] data_i,
    output logic [PC_W-1:0] top_o,
    output logic [SP_W-1:0] sp_o,
    output logic            full_o,
    output logic            empty_o
);

    logic [PC_W-1:0] mem_q [DEPTH];
    logic [SP_W-1:0] sp_q, sp_d;
    logic [AW-1:0]   top_idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                mem_q[i] <= '0;
            end else if (push_i && sp_q == SP_W'(i)) begin
                mem_q[i] <= data_i;
            end
        end
    end

    always_comb begin
        sp_d = sp_q;
        if (push_i)     sp_d = sp_q + SP_W'(1);
        else if (pop_i) sp_d = sp_q - SP_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sp_q <= '0;
        else         sp_q <= sp_d;
    end

    assign top_idx = AW'(sp_q - SP_W'(1));
    assign top_o   = mem_q[top_idx];
    assign sp_o    = sp_q;
    assign full_o  = (sp_q == SP_W'(DEPTH));
    assign empty_o = (sp_q == '0);

endmodule

// File: rtl/dslot_seq.sv
module dslot_seq
    import dslot_seq_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OFS_W  = 8,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16,
    localparam int BIT_W = $clog2(DATA_W),
    localparam int SP_W  = $clog2(DEPTH+1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic [3:0]        op_i,
    input  logic              rep_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [PC_W-1:0]   lit_i,
    input  logic              rem_load_i,
    input  logic [CNT_W-1:0]  rem_val_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [SP_W-1:0]   sp_o,
    output logic [PC_W-1:0]   lr_o,
    output logic [CNT_W-1:0]  rem_o,
    output logic              pend_o,
    output logic              err_o
);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  tgt;
        logic [PC_W-1:0]  lr;
        logic [CNT_W-1:0] rem;
        logic             err;
    } seq_state_t;

    seq_state_t s_q, s_d;

    seq_op_e          op_eff;
    logic             taken;
    logic             push, pop;
    logic             stk_full, stk_empty;
    logic [PC_W-1:0]  stk_top;
    logic [PC_W-1:0]  pc_next1, pc_link, br_tgt;
    logic             hold;

    assign op_eff   = rep_i ? OP_NONE : seq_op_e'(op_i);
    assign pc_next1 = s_q.pc + PC_W'(1);
    assign pc_link  = s_q.pc + PC_W'(2);
    assign br_tgt   = s_q.pc + {{(PC_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
    assign hold     = rep_i && (s_q.rem > CNT_W'(1));

    dslot_cond #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_cond (
        .op_i    (op_eff),
        .opnd_i  (opnd_i),
        .imm_i   (imm_i),
        .bit_i   (bit_i),
        .taken_o (taken)
    );

    dslot_stack #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W)
    ) u_stack (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (push),
        .pop_i   (pop),
        .data_i  (pc_link),
        .top_o   (stk_top),
        .sp_o    (sp_o),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        push    = 1'b0;
        pop     = 1'b0;
        if (step_i) begin
            // consume the pending target unless a repeat keeps this instruction
            if (!hold) begin
                s_d.tgt = '0;
                s_d.pc  = (s_q.tgt != '0) ? s_q.tgt : pc_next1;
            end
            if (rep_i && s_q.rem != '0) s_d.rem = s_q.rem - CNT_W'(1);
            case (op_eff)
                OP_BNE_I, OP_BEQ_I, OP_BCLR, OP_BSET: begin
                    if (taken) s_d.tgt = br_tgt;
                end
                OP_CALL: begin
                    if (stk_full) begin
                        s_d.err = 1'b1;
                    end else begin
                        push    = 1'b1;
                        s_d.tgt = lit_i;
                    end
                end
                OP_RET: begin
                    if (stk_empty) begin
                        s_d.err = 1'b1;
                    end else begin
                        pop     = 1'b1;
                        s_d.tgt = stk_top;
                    end
                end
                OP_BL: begin
                    s_d.lr  = pc_link;
                    s_d.tgt = lit_i;
                end
                OP_JR:   s_d.tgt = opnd_i[PC_W-1:0];
                OP_SRET: s_d.tgt = s_q.lr;
                OP_WAIT: begin
                    if (s_q.tgt != '0) s_d.err = 1'b1;
                end
                default: ;
            endcase
        end
        if (rem_load_i) s_d.rem = rem_val_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pc_o   = s_q.pc;
    assign lr_o   = s_q.lr;
    assign rem_o  = s_q.rem;
    assign pend_o = (s_q.tgt != '0);
    assign err_o  = s_q.err;

endmodule

// File: rtl/dslot_seq_chk.sv
module dslot_seq_chk #(
    parameter int PC_W  = 12,
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    localparam int SP_W = $clog2(DEPTH+1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             step_i,
    input logic [3:0]       op_i,
    input logic             rep_i,
    input logic             rem_load_i,
    input logic [PC_W-1:0]  pc_o,
    input logic [SP_W-1:0]  sp_o,
    input logic [CNT_W-1:0] rem_o,
    input logic             pend_o,
    input logic             err_o
);

    p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(pc_o) && $stable(sp_o));

    p_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !pend_o && !rep_i |=> pc_o == $past(pc_o) + PC_W'(1));

    p_call_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !rep_i && op_i == 4'd5 && sp_o < SP_W'(DEPTH)
        |=> sp_o == $past(sp_o) + SP_W'(1));

    p_sp_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sp_o <= SP_W'(DEPTH));

    p_err_sp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $stable(sp_o));

    p_rep_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && rep_i && !rem_load_i && rem_o > CNT_W'(1)
        |=> pc_o == $past(pc_o) && rem_o == $past(rem_o) - CNT_W'(1));

    p_rep_skip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && rep_i && !rem_load_i && rem_o == '0 |=> rem_o == '0);

    p_rem_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i && !rem_load_i |=> $stable(rem_o));

    p_wait_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !rep_i && op_i == 4'd10 && pend_o |=> err_o);

endmodule

bind dslot_seq dslot_seq_chk #(
    .PC_W  (PC_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_i),
    .op_i       (op_i),
    .rep_i      (rep_i),
    .rem_load_i (rem_load_i),
    .pc_o       (pc_o),
    .sp_o       (sp_o),
    .rem_o      (rem_o),
    .pend_o     (pend_o),
    .err_o      (err_o)
);

// File: tb/dslot_seq_tb.sv
module dslot_seq_tb;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        step_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic        rep_i = 1'b0;
    logic [31:0] opnd_i = '0;
    logic [15:0] imm_i = '0;
    logic [4:0]  bit_i = '0;
    logic [7:0]  ofs_i = '0;
    logic [11:0] lit_i = '0;
    logic        rem_load_i = 1'b0;
    logic [15:0] rem_val_i = '0;
    logic [11:0] pc_o;
    logic [3:0]  sp_o;
    logic [11:0] lr_o;
    logic [15:0] rem_o;
    logic        pend_o;
    logic        err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk_i = ~clk_i;

    dslot_seq u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .op_i(op_i), .rep_i(rep_i),
        .opnd_i(opnd_i), .imm_i(imm_i), .bit_i(bit_i), .ofs_i(ofs_i), .lit_i(lit_i),
        .rem_load_i(rem_load_i), .rem_val_i(rem_val_i), .pc_o(pc_o), .sp_o(sp_o),
        .lr_o(lr_o), .rem_o(rem_o), .pend_o(pend_o), .err_o(err_o)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] opnd;
        logic [15:0] imm;
        logic [4:0]  bitn;
        logic [7:0]  ofs;
        logic [11:0] lit;
        logic [11:0] exp_pc;
        logic [3:0]  exp_sp;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd1,   4'd0, 1'b0, 4'd3},  // R3 plain
        '{4'd2,  32'd5,    16'd5, 5'd0, 8'd10,  12'd0,   12'd2,   4'd0, 1'b0, 4'd4},  // R4 equal taken
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd11,  4'd0, 1'b0, 4'd5},  // R5 slot
        '{4'd1,  32'd5,    16'd5, 5'd0, 8'd3,   12'd0,   12'd12,  4'd0, 1'b0, 4'd4},  // R4 ne not taken
        '{4'd1,  32'd6,    16'd5, 5'd0, 8'hFC,  12'd0,   12'd13,  4'd0, 1'b0, 4'd4},  // R4 ne taken back
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd8,   4'd0, 1'b0, 4'd5},  // R5
        '{4'd4,  32'h10,   16'd0, 5'd4, 8'd20,  12'd0,   12'd9,   4'd0, 1'b0, 4'd4},  // R4 bit set taken
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd28,  4'd0, 1'b0, 4'd5},  // R5
        '{4'd3,  32'h10,   16'd0, 5'd4, 8'd5,   12'd0,   12'd29,  4'd0, 1'b0, 4'd4},  // R4 bit clear not taken
        '{4'd3,  32'h10,   16'd0, 5'd3, 8'd2,   12'd0,   12'd30,  4'd0, 1'b0, 4'd4},  // R4 bit clear taken
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd31,  4'd0, 1'b0, 4'd4},  // R4
        '{4'd2,  32'd5,    16'd6, 5'd0, 8'd9,   12'd0,   12'd32,  4'd0, 1'b0, 4'd4},  // R4 equal not taken
        '{4'd5,  32'd0,    16'd0, 5'd0, 8'd0,   12'd100, 12'd33,  4'd1, 1'b0, 4'd6},  // R6 call
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd100, 4'd1, 1'b0, 4'd6},  // R6
        '{4'd6,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd101, 4'd0, 1'b0, 4'd6},  // R6 return
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd34,  4'd0, 1'b0, 4'd6},  // R6 back at pc+2
        '{4'd7,  32'd0,    16'd0, 5'd0, 8'd0,   12'd200, 12'd35,  4'd0, 1'b0, 4'd8},  // R8 link
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd200, 4'd0, 1'b0, 4'd8},  // R8
        '{4'd9,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd201, 4'd0, 1'b0, 4'd8},  // R8 link return
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd36,  4'd0, 1'b0, 4'd8},  // R8
        '{4'd8,  32'h50,   16'd0, 5'd0, 8'd0,   12'd0,   12'd37,  4'd0, 1'b0, 4'd8},  // R8 jump reg
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd80,  4'd0, 1'b0, 4'd8},  // R8
        '{4'd4,  32'd1,    16'd0, 5'd0, 8'd4,   12'd0,   12'd81,  4'd0, 1'b0, 4'd4},  // R4
        '{4'd2,  32'd0,    16'd0, 5'd0, 8'd10,  12'd0,   12'd84,  4'd0, 1'b0, 4'd5},  // R5 branch in slot
        '{4'd0,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd91,  4'd0, 1'b0, 4'd5},  // R5
        '{4'd6,  32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd92,  4'd0, 1'b1, 4'd7},  // R7 empty return
        '{4'd10, 32'd0,    16'd0, 5'd0, 8'd0,   12'd0,   12'd93,  4'd0, 1'b0, 4'd11}  // R11 wait no pending
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_step(input logic [3:0] op, input logic rep, input logic [31:0] opnd,
                           input logic [15:0] imm, input logic [4:0] bn,
                           input logic [7:0] ofs, input logic [11:0] lit);
        op_i = op; rep_i = rep; opnd_i = opnd; imm_i = imm; bit_i = bn;
        ofs_i = ofs; lit_i = lit; step_i = 1'b1;
        @(negedge clk_i);
        step_i = 1'b0; rep_i = 1'b0; op_i = '0;
    endtask

    task automatic load_rem(input logic [15:0] v);
        rem_val_i = v; rem_load_i = 1'b1;
        @(negedge clk_i);
        rem_load_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        // R1 reset state
        chk("R1 pc", pc_o, 0);  chk("R1 sp", sp_o, 0);   chk("R1 lr", lr_o, 0);
        chk("R1 rem", rem_o, 0); chk("R1 pend", pend_o, 0); chk("R1 err", err_o, 0);

        for (int i = 0; i < NV; i++) begin
            do_step(VEC[i].op, 1'b0, VEC[i].opnd, VEC[i].imm, VEC[i].bitn, VEC[i].ofs, VEC[i].lit);
            chk($sformatf("R%0d pc vec%0d", VEC[i].req, i), pc_o, VEC[i].exp_pc);
            chk($sformatf("R6 sp vec%0d", i), sp_o, VEC[i].exp_sp);
            chk($sformatf("R7 err vec%0d", i), err_o, VEC[i].exp_err);
        end
        chk("R8 lr value", lr_o, 36);

        // R7 fill the stack, then overflow
        for (int k = 0; k < 8; k++) begin
            do_step(4'd5, 1'b0, 0, 0, 0, 0, 12'd300);
            do_step(4'd0, 1'b0, 0, 0, 0, 0, 0);
        end
        chk("R7 sp full", sp_o, 8);
        chk("R7 pc at callee", pc_o, 300);
        do_step(4'd5, 1'b0, 0, 0, 0, 0, 12'd300);
        chk("R7 overflow err", err_o, 1);
        chk("R7 overflow sp", sp_o, 8);
        chk("R7 overflow no target", pend_o, 0);
        do_step(4'd0, 1'b0, 0, 0, 0, 0, 0);
        chk("R7 overflow pc", pc_o, 302);
        chk("R7 err pulse ends", err_o, 0);
        do_step(4'd6, 1'b0, 0, 0, 0, 0, 0);
        do_step(4'd0, 1'b0, 0, 0, 0, 0, 0);
        chk("R6 return from full", pc_o, 302);
        chk("R6 sp after return", sp_o, 7);

        // R11 wait with pending target
        do_step(4'd2, 1'b0, 0, 0, 0, 8'd8, 0);
        do_step(4'd10, 1'b0, 0, 0, 0, 0, 0);
        chk("R11 wait err", err_o, 1);
        chk("R11 pc", pc_o, 310);

        // R9 R10 repeat
        load_rem(16'd3);
        chk("R10 load", rem_o, 3);
        chk("R10 load pc", pc_o, 310);
        do_step(4'd5, 1'b1, 0, 0, 0, 0, 12'd77);
        chk("R9 hold pc", pc_o, 310); chk("R9 rem 2", rem_o, 2); chk("R9 op ignored sp", sp_o, 7);
        do_step(4'd0, 1'b1, 0, 0, 0, 0, 0);
        chk("R9 hold pc", pc_o, 310); chk("R9 rem 1", rem_o, 1);
        do_step(4'd0, 1'b1, 0, 0, 0, 0, 0);
        chk("R9 last pass pc", pc_o, 311); chk("R9 rem 0", rem_o, 0);
        do_step(4'd0, 1'b1, 0, 0, 0, 0, 0);
        chk("R9 skip pc", pc_o, 312); chk("R9 skip rem", rem_o, 0);

        // R9 repeat in delay slot keeps target pending
        do_step(4'd1, 1'b0, 32'd1, 0, 0, 8'd20, 0);
        load_rem(16'd2);
        do_step(4'd0, 1'b1, 0, 0, 0, 0, 0);
        chk("R9 slot hold pc", pc_o, 313); chk("R9 slot pend", pend_o, 1); chk("R9 slot rem", rem_o, 1);
        do_step(4'd0, 1'b1, 0, 0, 0, 0, 0);
        chk("R9 slot jump", pc_o, 332); chk("R9 slot rem 0", rem_o, 0);

        // R2 no step: request fields ignored
        op_i = 4'd5; lit_i = 12'd500; opnd_i = 32'd9;
        repeat (3) @(negedge clk_i);
        chk("R2 pc", pc_o, 332); chk("R2 sp", sp_o, 7); chk("R2 pend", pend_o, 0); chk("R2 lr", lr_o, 36);
        op_i = '0;

        // R1 reset mid-run
        rst_ni = 1'b0;
        @(negedge clk_i);
        chk("R1 pc again", pc_o, 0); chk("R1 sp again", sp_o, 0);
        chk("R1 lr again", lr_o, 0); chk("R1 rem again", rem_o, 0);
        rst_ni = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule